// File: doc/BRIEF.md
# Multi-Cycle Fetch-Execute Sequencer with Interrupt Context Save

This block is the control core of a small accumulator processor. It has explicit program counter, memory address, memory buffer, instruction and status registers. Instructions and data share one memory port. That port has an address, write data, read data, separate read and write strobes, and a ready input from memory. Each instruction goes through its own states: a fetch that reads over the bus, a decode step, and an optional data access that reuses the address and buffer registers. An ALU step follows where the opcode needs one, and then a check for a pending interrupt request.

When the request line is high at that check and the core is not already in service, the core pushes four context words onto a descending stack at the top of memory and continues at a fixed service vector. The four words are:

- the return address
- the status word
- the accumulator
- the instruction register

A return instruction issued inside the service routine pops the four words in the opposite order. It then clears the service state and resumes the interrupted program.

Top module: `fetch_exec_seq`

## Requirements
- R1: While and right after reset, pc_o is 0, acc_o is 0, zero_o, ovf_o and in_svc_o are 0, and neither memory strobe is active.
- R2: An instruction word carries its opcode in bits 15:12 and an operand address in bits 11:0. Each fetch is a read at the current PC, and the PC is advanced by one before the instruction executes, so the first bus access after reset reads address 0 and the next fetch reads address 1.
- R3: mem_rd and mem_wr are never active together, so only one bus access is in flight at a time.
- R4: A strobe and its address stay unchanged until mem_ready is seen high, and any number of wait states leaves every result unchanged.
- R5: Opcode 1 loads memory into the accumulator, 2 stores the accumulator, 3 adds, 4 subtracts and 5 performs a bitwise AND, each with the word at the operand address.
- R6: Add, subtract and AND set zero_o when the result is 0. ovf_o is set on signed two's-complement overflow of add or subtract and cleared by AND. Load and store leave both flags unchanged.
- R7: Opcode 6 jumps to the operand address. Opcodes 0 and 8 to 15 change nothing and make no data access.
- R8: A high interrupt request is sampled only after an instruction completes. The core then writes the return PC, the status word {14'b0, ovf, zero}, the accumulator and the instruction word to addresses 0xFFF, 0xFFE, 0xFFD and 0xFFC in that order, and fetches next from the vector 0x0C0.
- R9: in_svc_o is high from service entry until a return completes, and no request is taken while it is high.
- R10: Opcode 7 in service reads 0xFFC, 0xFFD, 0xFFE and 0xFFF back into the instruction register, accumulator, status and PC, then clears in_svc_o. A request still high at that point re-enters service before any further fetch.
- R11: Opcode 7 outside service is a no-op that touches no stack location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Level interrupt request |
| mem_addr | output | 12 | Shared memory address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| mem_rd | output | 1 | Read strobe, held until ready |
| mem_wr | output | 1 | Write strobe, held until ready |
| mem_ready | input | 1 | Memory completes the current access |
| pc_o | output | 12 | Program counter |
| acc_o | output | 16 | Accumulator |
| zero_o | output | 1 | Zero flag |
| ovf_o | output | 1 | Signed overflow flag |
| in_svc_o | output | 1 | Service routine active (requests masked) |

## Verification
The check for an interrupt request and the end of a context restore can fall in the same step. This happens when a return completes while the request is still held high. The bench provokes it by keeping the request high through the whole first service routine. It then judges from the bus log that the access right after the final pop read at 0xFFF is a push write to 0xFFF, with no fetch in between. It also checks that the re-pushed accumulator and return address are the restored ones. A second test drops the request inside the routine, showing that the mask alone prevents nesting.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int OP_W = 4;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LOAD  = 4'd1,
    OP_STORE = 4'd2,
    OP_ADD   = 4'd3,
    OP_SUB   = 4'd4,
    OP_AND   = 4'd5,
    OP_JUMP  = 4'd6,
    OP_RETI  = 4'd7
  } op_e;

  typedef enum logic [3:0] {
    ST_FADDR,
    ST_FWAIT,
    ST_FLOAD,
    ST_DECODE,
    ST_DWAIT,
    ST_ALU,
    ST_CHECK,
    ST_PUSH,
    ST_PWAIT,
    ST_POP,
    ST_OWAIT,
    ST_OLOAD
  } state_e;

  typedef enum logic [1:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB,
    ALU_AND
  } alu_e;
endpackage

// File: rtl/fes_alu.sv
module fes_alu import fes_pkg::*; #(
  parameter int W = 16
) (
  input  alu_e         op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero,
  output logic         ovf
);
  always_comb begin
    y   = b;
    ovf = 1'b0;
    case (op)
      ALU_ADD: begin
        y   = a + b;
        ovf = (a[W-1] == b[W-1]) && (y[W-1] != a[W-1]);
      end
      ALU_SUB: begin
        y   = a - b;
        ovf = (a[W-1] != b[W-1]) && (y[W-1] != a[W-1]);
      end
      ALU_AND: y = a & b;
      default: y = b;
    endcase
    zero = (y == '0);
  end
endmodule

// File: rtl/fes_sp.sv
module fes_sp #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] push_addr,
  output logic [AW-1:0] pop_addr
);
  logic [AW-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (rst)       sp_q <= '1;
    else if (push) sp_q <= sp_q - 1'b1;
    else if (pop)  sp_q <= sp_q + 1'b1;
  end

  assign push_addr = sp_q;
  assign pop_addr  = sp_q + 1'b1;
endmodule

// File: rtl/fes_memif.sv
module fes_memif #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mar_ld,
  input  logic [AW-1:0] mar_d,
  input  logic          mbr_ld,
  input  logic [DW-1:0] mbr_d,
  input  logic          rd_go,
  input  logic          wr_go,
  output logic          done,
  output logic [DW-1:0] mbr_q,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic          mem_ready
);
  logic [AW-1:0] mar_q;
  logic          rd_q, wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_q <= '0;
      mbr_q <= '0;
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      if (mar_ld) mar_q <= mar_d;
      if (mbr_ld)                 mbr_q <= mbr_d;
      else if (rd_q && mem_ready) mbr_q <= mem_rdata;
      if (rd_q || wr_q) begin
        if (mem_ready) begin
          rd_q <= 1'b0;
          wr_q <= 1'b0;
        end
      end else begin
        rd_q <= rd_go;
        wr_q <= wr_go && !rd_go;
      end
    end
  end

  assign done      = (rd_q || wr_q) && mem_ready;
  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign mem_rd    = rd_q;
  assign mem_wr    = wr_q;
endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq import fes_pkg::*; #(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-OP_W-1:0] ISR_VEC = 'h0C0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   irq,
  output logic [DATA_W-OP_W-1:0] mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic [DATA_W-1:0]      mem_rdata,
  output logic                   mem_rd,
  output logic                   mem_wr,
  input  logic                   mem_ready,
  output logic [DATA_W-OP_W-1:0] pc_o,
  output logic [DATA_W-1:0]      acc_o,
  output logic                   zero_o,
  output logic                   ovf_o,
  output logic                   in_svc_o
);
  localparam int ADDR_W = DATA_W - OP_W;
  localparam int CTX_N  = 4;
  localparam int IDX_W  = $clog2(CTX_N);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CTX_N - 1);

  state_e            st_q, st_n;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] acc_q, cir_q;
  logic              zero_q, ovf_q, svc_q;
  logic [IDX_W-1:0]  idx_q;

  logic              mar_ld, mbr_ld, rd_go, wr_go, done;
  logic [ADDR_W-1:0] mar_d;
  logic [DATA_W-1:0] mbr_d, mbr_q, ctx_word;
  logic              sp_push, sp_pop;
  logic [ADDR_W-1:0] push_addr, pop_addr;
  logic [DATA_W-1:0] alu_y;
  logic              alu_z, alu_v;
  alu_e              alu_op;
  op_e               op;
  logic [ADDR_W-1:0] ir_addr;

  assign op      = op_e'(cir_q[DATA_W-1 -: OP_W]);
  assign ir_addr = cir_q[ADDR_W-1:0];

  always_comb begin
    case (op)
      OP_ADD:  alu_op = ALU_ADD;
      OP_SUB:  alu_op = ALU_SUB;
      OP_AND:  alu_op = ALU_AND;
      default: alu_op = ALU_PASS;
    endcase
  end

  always_comb begin
    case (idx_q)
      2'd0:    ctx_word = DATA_W'(pc_q);
      2'd1:    ctx_word = {{(DATA_W-2){1'b0}}, ovf_q, zero_q};
      2'd2:    ctx_word = acc_q;
      default: ctx_word = cir_q;
    endcase
  end

  fes_memif #(.DW(DATA_W), .AW(ADDR_W)) u_memif (
    .clk(clk), .rst(rst),
    .mar_ld(mar_ld), .mar_d(mar_d), .mbr_ld(mbr_ld), .mbr_d(mbr_d),
    .rd_go(rd_go), .wr_go(wr_go), .done(done), .mbr_q(mbr_q),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ready(mem_ready)
  );

  fes_sp #(.AW(ADDR_W)) u_sp (
    .clk(clk), .rst(rst), .push(sp_push), .pop(sp_pop),
    .push_addr(push_addr), .pop_addr(pop_addr)
  );

  fes_alu #(.W(DATA_W)) u_alu (
    .op(alu_op), .a(acc_q), .b(mbr_q), .y(alu_y), .zero(alu_z), .ovf(alu_v)
  );

  always_comb begin
    st_n    = st_q;
    mar_ld  = 1'b0;
    mar_d   = pc_q;
    mbr_ld  = 1'b0;
    mbr_d   = acc_q;
    rd_go   = 1'b0;
    wr_go   = 1'b0;
    sp_push = 1'b0;
    sp_pop  = 1'b0;
    case (st_q)
      ST_FADDR: begin
        mar_ld = 1'b1;
        rd_go  = 1'b1;
        st_n   = ST_FWAIT;
      end
      ST_FWAIT: if (done) st_n = ST_FLOAD;
      ST_FLOAD: st_n = ST_DECODE;
      ST_DECODE: begin
        case (op)
          OP_LOAD, OP_ADD, OP_SUB, OP_AND: begin
            mar_ld = 1'b1;
            mar_d  = ir_addr;
            rd_go  = 1'b1;
            st_n   = ST_DWAIT;
          end
          OP_STORE: begin
            mar_ld = 1'b1;
            mar_d  = ir_addr;
            mbr_ld = 1'b1;
            wr_go  = 1'b1;
            st_n   = ST_DWAIT;
          end
          OP_RETI: st_n = svc_q ? ST_POP : ST_CHECK;
          default: st_n = ST_CHECK;
        endcase
      end
      ST_DWAIT: if (done) st_n = (op == OP_STORE) ? ST_CHECK : ST_ALU;
      ST_ALU:   st_n = ST_CHECK;
      ST_CHECK: st_n = (irq && !svc_q) ? ST_PUSH : ST_FADDR;
      ST_PUSH: begin
        mar_ld  = 1'b1;
        mar_d   = push_addr;
        mbr_ld  = 1'b1;
        mbr_d   = ctx_word;
        wr_go   = 1'b1;
        sp_push = 1'b1;
        st_n    = ST_PWAIT;
      end
      ST_PWAIT: if (done) st_n = (idx_q == IDX_LAST) ? ST_FADDR : ST_PUSH;
      ST_POP: begin
        mar_ld = 1'b1;
        mar_d  = pop_addr;
        rd_go  = 1'b1;
        sp_pop = 1'b1;
        st_n   = ST_OWAIT;
      end
      ST_OWAIT: if (done) st_n = ST_OLOAD;
      ST_OLOAD: st_n = (idx_q == IDX_LAST) ? ST_CHECK : ST_POP;
      default:  st_n = ST_FADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_FADDR;
      pc_q   <= '0;
      acc_q  <= '0;
      cir_q  <= '0;
      zero_q <= 1'b0;
      ovf_q  <= 1'b0;
      svc_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      st_q <= st_n;
      case (st_q)
        ST_FADDR:  pc_q  <= pc_q + 1'b1;
        ST_FLOAD:  cir_q <= mbr_q;
        ST_DECODE: if (op == OP_JUMP) pc_q <= ir_addr;
        ST_ALU: begin
          acc_q <= alu_y;
          if (op != OP_LOAD) begin
            zero_q <= alu_z;
            ovf_q  <= alu_v;
          end
        end
        ST_CHECK: idx_q <= '0;
        ST_PWAIT: if (done) begin
          if (idx_q == IDX_LAST) begin
            pc_q  <= ISR_VEC;
            svc_q <= 1'b1;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_OLOAD: begin
          case (idx_q)
            2'd0:    cir_q <= mbr_q;
            2'd1:    acc_q <= mbr_q;
            2'd2:    {ovf_q, zero_q} <= mbr_q[1:0];
            default: pc_q <= mbr_q[ADDR_W-1:0];
          endcase
          if (idx_q == IDX_LAST) begin
            svc_q <= 1'b0;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign pc_o     = pc_q;
  assign acc_o    = acc_q;
  assign zero_o   = zero_q;
  assign ovf_o    = ovf_q;
  assign in_svc_o = svc_q;
endmodule

// File: rtl/fetch_exec_seq_chk.sv
module fetch_exec_seq_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ISR_VEC = 'h0C0
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] pc_o,
  input logic [DATA_W-1:0] acc_o,
  input logic              in_svc_o
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && acc_o == '0 && !in_svc_o && !mem_rd && !mem_wr));

  a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r4_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

  a_r4_wr_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr)));

  a_r8_vector: assert property (@(posedge clk) disable iff (rst)
    $rose(in_svc_o) |-> (pc_o == ISR_VEC));
endmodule

bind fetch_exec_seq fetch_exec_seq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ISR_VEC(ISR_VEC)
) u_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .pc_o(pc_o),
  .acc_o(acc_o), .in_svc_o(in_svc_o)
);

// File: tb/fetch_exec_seq_tb.sv
module fetch_exec_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr;
  logic        mem_ready = 1'b0;
  logic [11:0] pc_o;
  logic [15:0] acc_o;
  logic        zero_o, ovf_o, in_svc_o;

  int errors = 0;
  int checks = 0;
  int wait_n = 0;
  int wcnt   = 0;
  int drop_mode = 0;
  int fff_pushes = 0;
  logic saw_svc = 1'b0;

  // bench memory aliases the 12-bit address onto 256 words
  logic [15:0] mem [256];
  logic [12:0] log_q [64];
  int log_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_exec_seq u_dut (
    .clk(clk), .rst(rst), .irq(irq), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ready(mem_ready),
    .pc_o(pc_o), .acc_o(acc_o), .zero_o(zero_o), .ovf_o(ovf_o), .in_svc_o(in_svc_o)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(negedge clk) begin
    if (mem_rd || mem_wr) begin
      if (wcnt >= wait_n) mem_ready <= 1'b1;
      else begin
        wcnt <= wcnt + 1;
        mem_ready <= 1'b0;
      end
    end else begin
      wcnt <= 0;
      mem_ready <= 1'b0;
    end
    if (rst) saw_svc <= 1'b0;
    else if (in_svc_o) saw_svc <= 1'b1;
    case (drop_mode)
      1: if (in_svc_o) irq <= 1'b0;
      2: if (mem_wr && mem_addr == 12'h085) irq <= 1'b0;
      3: if (fff_pushes == 2) irq <= 1'b0;
      default: ;
    endcase
  end

  always @(posedge clk) begin
    if (rst) begin
      log_n <= 0;
      fff_pushes <= 0;
    end else if ((mem_rd || mem_wr) && mem_ready) begin
      if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
      if (log_n < 64) begin
        log_q[log_n] <= {mem_wr, mem_addr};
        log_n <= log_n + 1;
      end
      if (mem_wr && mem_addr == 12'hFFF) fff_pushes <= fff_pushes + 1;
    end
  end

  function automatic logic [15:0] ins(input int op, input int a);
    return {op[3:0], a[11:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic begin_test(input int ws, input int mode);
    @(negedge clk);
    rst = 1'b1;
    irq = 1'b0;
    wait_n = ws;
    drop_mode = mode;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
  endtask

  task automatic run(input int n);
    rst = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic int count_push();
    int c = 0;
    for (int i = 0; i < log_n; i++)
      if (log_q[i][12] && log_q[i][11:0] >= 12'hFFC) c++;
    return c;
  endfunction

  task automatic t_reset();
    begin_test(0, 0);
    chk("R1 pc", 32'(pc_o), 0);
    chk("R1 acc", 32'(acc_o), 0);
    chk("R1 flags", {30'd0, ovf_o, zero_o}, 0);
    chk("R1 svc", 32'(in_svc_o), 0);
    chk("R1 strobes", {30'd0, mem_rd, mem_wr}, 0);
  endtask

  task automatic load_arith();
    mem[8'h00] = ins(1, 12'h080);
    mem[8'h01] = ins(3, 12'h081);
    mem[8'h02] = ins(2, 12'h082);
    mem[8'h03] = ins(4, 12'h081);
    mem[8'h04] = ins(4, 12'h080);
    mem[8'h05] = ins(2, 12'h083);
    mem[8'h06] = ins(6, 12'h006);
    mem[8'h80] = 16'd5;
    mem[8'h81] = 16'd7;
    mem[8'h83] = 16'hDEAD;
  endtask

  task automatic t_arith();
    begin_test(0, 0);
    load_arith();
    run(300);
    chk("R2 first fetch at 0", 32'(log_q[0]), {19'd0, 1'b0, 12'h000});
    chk("R2 operand read", 32'(log_q[1]), {19'd0, 1'b0, 12'h080});
    chk("R2 second fetch at 1", 32'(log_q[2]), {19'd0, 1'b0, 12'h001});
    chk("R5 store write", 32'(log_q[5]), {19'd0, 1'b1, 12'h082});
    chk("R5 add result", 32'(mem[8'h82]), 12);
    chk("R5 sub to zero", 32'(mem[8'h83]), 0);
    chk("R6 zero set", 32'(zero_o), 1);
    chk("R6 ovf clear", 32'(ovf_o), 0);
  endtask

  task automatic t_wait();
    begin_test(3, 0);
    load_arith();
    run(900);
    chk("R4 store write order", 32'(log_q[5]), {19'd0, 1'b1, 12'h082});
    chk("R4 add result with waits", 32'(mem[8'h82]), 12);
    chk("R4 sub result with waits", 32'(mem[8'h83]), 0);
  endtask

  task automatic t_ovf();
    begin_test(0, 0);
    mem[8'h00] = ins(1, 12'h080);
    mem[8'h01] = ins(3, 12'h081);
    mem[8'h02] = ins(2, 12'h082);
    mem[8'h03] = ins(6, 12'h003);
    mem[8'h80] = 16'h7FFF;
    mem[8'h81] = 16'h0001;
    run(200);
    chk("R6 add result", 32'(mem[8'h82]), 32'h8000);
    chk("R6 add ovf", 32'(ovf_o), 1);
    chk("R6 add nonzero", 32'(zero_o), 0);
    begin_test(0, 0);
    mem[8'h00] = ins(1, 12'h080);
    mem[8'h01] = ins(4, 12'h081);
    mem[8'h02] = ins(2, 12'h084);
    mem[8'h03] = ins(5, 12'h082);
    mem[8'h04] = ins(1, 12'h083);
    mem[8'h05] = ins(6, 12'h005);
    mem[8'h80] = 16'h8000;
    mem[8'h81] = 16'h0001;
    mem[8'h83] = 16'h0005;
    run(250);
    chk("R5 sub wrap", 32'(mem[8'h84]), 32'h7FFF);
    chk("R6 load keeps zero", 32'(zero_o), 1);
    chk("R6 and clears ovf", 32'(ovf_o), 0);
    chk("R5 load value", 32'(acc_o), 5);
  endtask

  task automatic t_jump_nop();
    begin_test(0, 0);
    mem[8'h00] = ins(15, 12'h080);
    mem[8'h01] = ins(0, 12'h080);
    mem[8'h02] = ins(6, 12'h004);
    mem[8'h03] = ins(2, 12'h085);
    mem[8'h04] = ins(1, 12'h080);
    mem[8'h05] = ins(9, 12'h081);
    mem[8'h06] = ins(2, 12'h086);
    mem[8'h07] = ins(6, 12'h007);
    mem[8'h80] = 16'h0055;
    mem[8'h85] = 16'hDEAD;
    run(300);
    chk("R7 nop makes no data read", 32'(log_q[1]), {19'd0, 1'b0, 12'h001});
    chk("R7 jumped over store", 32'(mem[8'h85]), 32'hDEAD);
    chk("R7 store after jump", 32'(mem[8'h86]), 32'h0055);
    chk("R7 nop keeps acc", 32'(acc_o), 32'h0055);
  endtask

  task automatic load_isr_prog();
    mem[8'h00] = ins(1, 12'h080);
    mem[8'h01] = ins(2, 12'h086);
    mem[8'h02] = ins(6, 12'h002);
    mem[8'hC0] = ins(5, 12'h084);
    mem[8'hC1] = ins(2, 12'h085);
    mem[8'hC2] = ins(7, 12'h000);
    mem[8'h80] = 16'h1234;
    mem[8'h85] = 16'hDEAD;
    mem[8'h86] = 16'hDEAD;
  endtask

  task automatic t_irq();
    begin_test(0, 1);
    load_isr_prog();
    irq = 1'b1;
    run(400);
    chk("R8 after load read", 32'(log_q[1]), {19'd0, 1'b0, 12'h080});
    chk("R8 push pc", 32'(log_q[2]), {19'd0, 1'b1, 12'hFFF});
    chk("R8 push last", 32'(log_q[5]), {19'd0, 1'b1, 12'hFFC});
    chk("R8 vector fetch", 32'(log_q[6]), {19'd0, 1'b0, 12'h0C0});
    chk("R8 saved pc", 32'(mem[8'hFF]), 1);
    chk("R8 saved status", 32'(mem[8'hFE]), 0);
    chk("R8 saved acc", 32'(mem[8'hFD]), 32'h1234);
    chk("R8 saved cir", 32'(mem[8'hFC]), 32'h1080);
    chk("R9 service seen", 32'(saw_svc), 1);
    chk("R5 service store", 32'(mem[8'h85]), 0);
    chk("R10 acc restored", 32'(mem[8'h86]), 32'h1234);
    chk("R10 zero restored", 32'(zero_o), 0);
    chk("R10 service cleared", 32'(in_svc_o), 0);
  endtask

  task automatic t_mask();
    begin_test(0, 2);
    load_isr_prog();
    irq = 1'b1;
    run(400);
    chk("R9 single push set", count_push(), 4);
    chk("R9 program resumed", 32'(mem[8'h86]), 32'h1234);
  endtask

  task automatic t_reenter();
    int pos;
    begin_test(0, 3);
    load_isr_prog();
    irq = 1'b1;
    run(600);
    pos = -1;
    for (int i = 0; i < log_n; i++)
      if (pos < 0 && !log_q[i][12] && log_q[i][11:0] == 12'hFFF) pos = i;
    chk("R10 pop of pc seen", 32'(pos >= 0), 1);
    if (pos >= 0)
      chk("R10 re-entry before fetch", 32'(log_q[pos+1]), {19'd0, 1'b1, 12'hFFF});
    chk("R10 two push sets", count_push(), 8);
    chk("R10 re-pushed acc", 32'(mem[8'hFD]), 32'h1234);
    chk("R10 re-pushed pc", 32'(mem[8'hFF]), 1);
    chk("R10 final resume", 32'(mem[8'h86]), 32'h1234);
  endtask

  task automatic t_reti_outside();
    begin_test(0, 0);
    mem[8'h00] = ins(7, 12'h000);
    mem[8'h01] = ins(1, 12'h080);
    mem[8'h02] = ins(2, 12'h086);
    mem[8'h03] = ins(6, 12'h003);
    mem[8'h80] = 16'h0042;
    run(200);
    chk("R11 no stack read", 32'(log_q[1]), {19'd0, 1'b0, 12'h001});
    chk("R11 program continues", 32'(mem[8'h86]), 32'h0042);
    chk("R11 not in service", 32'(in_svc_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_arith();
    t_wait();
    t_ovf();
    t_jump_nop();
    t_irq();
    t_mask();
    t_reenter();
    t_reti_outside();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule